// File: doc/BRIEF.md
# Configuration Register Write Guard

This block sits between a simple memory-mapped bus and the configuration registers of a serial peripheral. It holds the seven configuration words itself, two freely writable general-purpose words, a keyed protection-mode register and a read-only violation status word. Software first writes the mode register with the correct key and the enable bit set. From then on, any attempt to overwrite a configuration word is dropped. The attempt is remembered in a sticky flag, together with the word offset of the register that was targeted.

The only way to lift protection or to clear the record of violations is another keyed write to the mode register. A mode write with a bad key has no effect at all. Reading the status word never changes it, so diagnostic code can poll it freely. The configuration words are driven out in parallel on `cfg_q` for the peripheral to use.

Word offsets are fixed: configuration words at 0 to 6, mode at 7, status at 8, general-purpose words at 9 and 10. Read data is registered and appears on `bus_rdata` in the cycle after `bus_rd` is high.

Top module: `regprot_unit`

## Requirements
- R1: After reset, protection is off, the status word reads 0, the mode word reads 0 and every configuration word is 0.
- R2: While protection is off, a write to any configuration word (offsets 0 to 6) stores the data, and the stored value reads back.
- R3: A write to the mode word (offset 7) whose bits 31:8 equal 0x535343 sets the protection enable to bit 0 of the data. This applies whether protection is on or off.
- R4: A mode write with any other key changes neither the enable nor the status word.
- R5: While protection is on, a write to a configuration word leaves its contents unchanged.
- R6: A blocked write sets status bit 0. The bit stays set through reads and through later writes, until a keyed mode write.
- R7: Status bits 23:8 hold the word offset of the most recent blocked write. A later blocked write overwrites this field.
- R8: A keyed mode write clears both the flag and the offset field of the status word.
- R9: The general-purpose words (offsets 9 and 10) accept writes regardless of protection. Writes to the status word (offset 8) are ignored.
- R10: Read data appears one cycle after the read strobe, and reading has no side effect. The mode word reads back as the enable in bit 0 with all other bits 0.
- R11: `cfg_q` carries configuration word i in bits 32*i+31 : 32*i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| cfg_q | output | 32*NUM_CFG | Configuration words, in parallel |

## Verification
The hardest state to reach is a second violation landing on top of a flag that is already set. Reaching it while a rejected mode write sits between the two violations is harder still. The stimulus enables protection with a proper key and blocks a write to offset 3. It then writes the general-purpose and status words, sends a mode write with a wrong key, and blocks a write to offset 6. Each step is followed by a status read, so the sticky flag and the overwritten offset are both seen at the port.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int WORD_W  = 32;
  localparam int KEY_LSB = 8;
  localparam int KEY_W   = 24;
  localparam int SRC_LSB = 8;
  localparam int SRC_W   = 16;
  localparam logic [KEY_W-1:0] PROT_KEY = 24'h535343;

  typedef struct packed {
    logic             flag;
    logic [SRC_W-1:0] src;
  } viol_t;

  function automatic logic key_ok(input logic [KEY_W-1:0] k);
    return k == PROT_KEY;
  endfunction

  function automatic logic [WORD_W-1:0] status_word(input viol_t v);
    logic [WORD_W-1:0] w;
    w = '0;
    w[0] = v.flag;
    w[SRC_LSB +: SRC_W] = v.src;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] mode_word(input logic en);
    logic [WORD_W-1:0] w;
    w = '0;
    w[0] = en;
    return w;
  endfunction
endpackage

// File: rtl/wp_decode.sv
module wp_decode #(
  parameter int ADDR_W   = 8,
  parameter int NUM_CFG  = 7,
  parameter int NUM_OPEN = 2
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_CFG-1:0]  hit_cfg,
  output logic                hit_mode,
  output logic                hit_stat,
  output logic [NUM_OPEN-1:0] hit_open
);
  localparam int MODE_OFS = NUM_CFG;
  localparam int STAT_OFS = NUM_CFG + 1;
  localparam int OPEN_OFS = NUM_CFG + 2;

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
    assign hit_cfg[i] = (addr == ADDR_W'(i));
  end

  for (genvar j = 0; j < NUM_OPEN; j++) begin : g_open
    assign hit_open[j] = (addr == ADDR_W'(OPEN_OFS + j));
  end

  assign hit_mode = (addr == ADDR_W'(MODE_OFS));
  assign hit_stat = (addr == ADDR_W'(STAT_OFS));
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              hit_cfg_any,
  input  logic              hit_mode,
  input  logic [KEY_W-1:0]  key_in,
  input  logic              en_in,
  input  logic [ADDR_W-1:0] addr,
  output logic              prot_en,
  output viol_t             viol,
  output logic              key_match,
  output logic              blocked,
  output logic              mode_commit,
  output logic              cfg_pass
);
  assign key_match   = key_ok(key_in);
  assign mode_commit = wr_req & hit_mode & key_match;
  assign blocked     = wr_req & hit_cfg_any & prot_en;
  assign cfg_pass    = wr_req & ~prot_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_en <= 1'b0;
      viol    <= '0;
    end else if (mode_commit) begin
      prot_en <= en_in;
      viol    <= '0;
    end else if (blocked) begin
      viol.flag <= 1'b1;
      viol.src  <= SRC_W'(addr);
    end
  end
endmodule

// File: rtl/wp_bank.sv
module wp_bank #(
  parameter int N = 7,
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   we,
  input  logic [W-1:0]   wdata,
  output logic [N*W-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)     q[i*W +: W] <= '0;
      else if (we[i]) q[i*W +: W] <= wdata;
    end
  end
endmodule

// File: rtl/wp_readmux.sv
module wp_readmux
  import wp_pkg::*;
#(
  parameter int NUM_CFG  = 7,
  parameter int NUM_OPEN = 2
) (
  input  logic [NUM_CFG-1:0]         hit_cfg,
  input  logic                       hit_mode,
  input  logic                       hit_stat,
  input  logic [NUM_OPEN-1:0]        hit_open,
  input  logic [NUM_CFG*WORD_W-1:0]  cfg_flat,
  input  logic [NUM_OPEN*WORD_W-1:0] open_flat,
  input  logic                       prot_en,
  input  viol_t                      viol,
  output logic [WORD_W-1:0]          word
);
  always_comb begin
    word = '0;
    for (int i = 0; i < NUM_CFG; i++)
      if (hit_cfg[i]) word = word | cfg_flat[i*WORD_W +: WORD_W];
    for (int j = 0; j < NUM_OPEN; j++)
      if (hit_open[j]) word = word | open_flat[j*WORD_W +: WORD_W];
    if (hit_mode) word = word | mode_word(prot_en);
    if (hit_stat) word = word | status_word(viol);
  end
endmodule

// File: rtl/regprot_unit.sv
module regprot_unit
  import wp_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_CFG  = 7,
  parameter int NUM_OPEN = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic [WORD_W-1:0]         bus_wdata,
  input  logic                      bus_rd,
  output logic [WORD_W-1:0]         bus_rdata,
  output logic [NUM_CFG*WORD_W-1:0] cfg_q
);
  logic [NUM_CFG-1:0]         hit_cfg;
  logic [NUM_OPEN-1:0]        hit_open;
  logic                       hit_mode;
  logic                       hit_stat;
  logic                       hit_cfg_any;
  logic                       prot_en;
  viol_t                      viol;
  logic                       key_match;
  logic                       blocked;
  logic                       mode_commit;
  logic                       cfg_pass;
  logic [NUM_CFG-1:0]         cfg_we;
  logic [NUM_OPEN-1:0]        open_we;
  logic [NUM_OPEN*WORD_W-1:0] open_q;
  logic [WORD_W-1:0]          rd_word;

  wp_decode #(.ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG), .NUM_OPEN(NUM_OPEN)) u_dec (
    .addr     (bus_addr),
    .hit_cfg  (hit_cfg),
    .hit_mode (hit_mode),
    .hit_stat (hit_stat),
    .hit_open (hit_open)
  );

  assign hit_cfg_any = |hit_cfg;

  wp_guard #(.ADDR_W(ADDR_W)) u_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_req      (bus_wr),
    .hit_cfg_any (hit_cfg_any),
    .hit_mode    (hit_mode),
    .key_in      (bus_wdata[KEY_LSB +: KEY_W]),
    .en_in       (bus_wdata[0]),
    .addr        (bus_addr),
    .prot_en     (prot_en),
    .viol        (viol),
    .key_match   (key_match),
    .blocked     (blocked),
    .mode_commit (mode_commit),
    .cfg_pass    (cfg_pass)
  );

  assign cfg_we  = hit_cfg & {NUM_CFG{cfg_pass}};
  assign open_we = hit_open & {NUM_OPEN{bus_wr}};

  wp_bank #(.N(NUM_CFG), .W(WORD_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (bus_wdata),
    .q     (cfg_q)
  );

  wp_bank #(.N(NUM_OPEN), .W(WORD_W)) u_open (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (open_we),
    .wdata (bus_wdata),
    .q     (open_q)
  );

  wp_readmux #(.NUM_CFG(NUM_CFG), .NUM_OPEN(NUM_OPEN)) u_rmux (
    .hit_cfg   (hit_cfg),
    .hit_mode  (hit_mode),
    .hit_stat  (hit_stat),
    .hit_open  (hit_open),
    .cfg_flat  (cfg_q),
    .open_flat (open_q),
    .prot_en   (prot_en),
    .viol      (viol),
    .word      (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end
endmodule

// File: rtl/regprot_unit_chk.sv
module regprot_unit_chk
  import wp_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_CFG = 7
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_wr,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [WORD_W-1:0]         bus_wdata,
  input logic                      hit_mode,
  input logic                      key_match,
  input logic                      blocked,
  input logic                      prot_en,
  input viol_t                     viol,
  input logic [NUM_CFG*WORD_W-1:0] cfg_q
);
  logic keyed;
  assign keyed = bus_wr & hit_mode & key_match;

  AST_BLOCK_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> $stable(cfg_q)); // R5
  AST_BLOCK_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> viol.flag); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    viol.flag && !keyed |=> viol.flag); // R6
  AST_SRC_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> viol.src == SRC_W'($past(bus_addr))); // R7
  AST_KEY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    keyed |=> !viol.flag && viol.src == '0); // R8
  AST_KEY_SETS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    keyed |=> prot_en == $past(bus_wdata[0])); // R3
  AST_BADKEY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && hit_mode && !key_match |=> $stable(prot_en) && $stable(viol)); // R4
  AST_OFF_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_en && !viol.flag |=> !viol.flag); // R2
endmodule

bind regprot_unit regprot_unit_chk #(.ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .hit_mode  (hit_mode),
  .key_match (key_match),
  .blocked   (blocked),
  .prot_en   (prot_en),
  .viol      (viol),
  .cfg_q     (cfg_q)
);

// File: tb/regprot_unit_test.sv
module regprot_unit_test;
  localparam int PERIOD = 10;
  localparam int AW = 8;
  localparam int NC = 7;
  localparam logic [23:0] KEY = 24'h535343;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [NC*32-1:0] cfg_q;

  always #(PERIOD/2) clk = ~clk;

  regprot_unit #(.ADDR_W(AW), .NUM_CFG(NC), .NUM_OPEN(2)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .cfg_q(cfg_q)
  );

  typedef struct {
    logic [31:0] exp;
    logic [AW-1:0] addr;
    string tag;
  } item_t;
  item_t sb[$];

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] m_cfg [NC];
  logic [31:0] m_open [2];
  logic m_en;
  logic m_flag;
  logic [15:0] m_src;

  function automatic logic [31:0] model_read(input int a);
    if (a < NC) return m_cfg[a];
    if (a == 7) return {31'b0, m_en};
    if (a == 8) return {8'b0, m_src, 7'b0, m_flag};
    if (a == 9 || a == 10) return m_open[a-9];
    return 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a < NC) begin
      if (m_en) begin m_flag = 1'b1; m_src = 16'(a); end
      else m_cfg[a] = d;
    end else if (a == 7) begin
      if (d[31:8] == KEY) begin m_en = d[0]; m_flag = 1'b0; m_src = '0; end
    end else if (a == 9 || a == 10) begin
      m_open[a-9] = d;
    end
  endtask

  task automatic rd(input int a, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = model_read(a); it.addr = AW'(a); it.tag = tag;
    sb.push_back(it);
    bus_addr = AW'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_cfg(input string tag);
    @(negedge clk);
    for (int i = 0; i < NC; i++) check(tag, cfg_q[i*32 +: 32], m_cfg[i]);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (sb.size() == 0) check("scoreboard underflow", 32'h1, 32'h0);
        else begin
          it = sb.pop_front();
          check(it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin : stim
    for (int i = 0; i < NC; i++) m_cfg[i] = '0;
    m_open[0] = '0; m_open[1] = '0;
    m_en = 1'b0; m_flag = 1'b0; m_src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk_cfg("R1 R11 reset cfg");
    rd(8, "R1 status after reset");
    rd(7, "R1 mode after reset");
    // R2: open writes land
    for (int i = 0; i < NC; i++) wr(i, 32'hA5000000 + 32'(i * 17));
    for (int i = 0; i < NC; i++) rd(i, "R2 readback unprotected");
    chk_cfg("R11 cfg_q after writes");
    // R4: wrong key
    wr(7, {24'h535342, 8'h01});
    rd(7, "R4 wrong key keeps enable off");
    // R3: correct key
    wr(7, {KEY, 8'h01});
    rd(7, "R3 keyed enable");
    // R5 R6 R7: block cfg3
    wr(3, 32'hDEADBEEF);
    rd(3, "R5 blocked word unchanged");
    rd(8, "R6 R7 status after block at 3");
    rd(8, "R10 second status read identical");
    chk_cfg("R5 cfg_q unchanged");
    // R9: open and status writes
    wr(9, 32'h12345678);
    wr(10, 32'h0BADF00D);
    rd(9, "R9 open word 9 writable");
    rd(10, "R9 open word 10 writable");
    wr(8, 32'hFFFFFFFF);
    rd(8, "R9 status write ignored");
    // R4: wrong key while flagged
    wr(7, {24'h000000, 8'h00});
    rd(7, "R4 bad key keeps enable on");
    rd(8, "R4 bad key keeps flag");
    // R7: overwrite source
    wr(6, 32'h11111111);
    rd(8, "R7 source overwritten to 6");
    rd(6, "R5 word 6 unchanged");
    // R8: keyed write clears
    wr(7, {KEY, 8'h01});
    rd(8, "R8 keyed write clears status");
    rd(7, "R3 enable kept on");
    wr(0, 32'h0);
    rd(8, "R7 source offset 0");
    wr(7, {KEY, 8'hFE});
    rd(7, "R10 mode reads enable only");
    rd(8, "R8 cleared on disable");
    wr(0, 32'hCAFE0000);
    rd(0, "R2 write lands after disable");
    chk_cfg("R11 final cfg_q");
    repeat (4) @(negedge clk);
    check("scoreboard drained", 32'(sb.size()), 32'h0);
    finish_run();
  end
endmodule